// File: doc/BRIEF.md
# Calibrated ADC Code to Millivolt Converter

This block turns a raw 12-bit converter code into a voltage in millivolts. It places the code on a straight line through two calibration points, one line for a big measurement range (points at 4200 mV and 3600 mV) and one for a small range (1000 mV and 100 mV). The result is clamped so it never goes below zero. For most channels the block then rescales that voltage by a divider ratio supplied with the request and rounds the result to the nearest integer. All division in the block goes through one shared multi-cycle restoring divider.

The code points of each line come from a 16-bit calibration word. The low byte gives the high-voltage point and the high byte gives the low-voltage point. Each byte is an offset that is added to a per-point nominal code. Until a word has been loaded for a range, that range uses fixed uncalibrated points. Requests arrive on a valid/ready handshake. The block works on one request at a time and presents each answer with a one-cycle valid pulse and an error flag.

Top module: `adcv_conv_top`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `out_valid` is 0, `out_mv` is 0 and `out_err` is 0.
- R2: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until `out_valid` has pulsed high for exactly one cycle. `in_ready` returns to 1 in the cycle after that pulse.
- R3: The interpolated voltage is v1 + (v0 − v1)·(code − a1)/(a0 − a1) in signed integer arithmetic. The division truncates toward zero.
- R4: A negative interpolated voltage is replaced by 0 before any further step.
- R5: Channel 5 always uses the big range (v0 = 4200, v1 = 3600). It returns the interpolated voltage without rescaling, whatever `in_big` and `in_ratio` are.
- R6: Channel 1 always uses the small range (v0 = 1000, v1 = 100). It returns the interpolated voltage without rescaling, whatever `in_big` and `in_ratio` are.
- R7: Every other channel uses the range picked by `in_big` (1 = big, 0 = small). The interpolated voltage V is then rescaled to (V·d + n/2)/n with unsigned truncating division, where n = `in_ratio[31:16]` and d = `in_ratio[15:0]`.
- R8: A pulse on `cal_load` stores `cal_word` for the range picked by `cal_big` (1 = big). The new points are a0 = (`cal_word[7:0]` + N0 − 128)·4 and a1 = (`cal_word[15:8]` + N1 − 128)·4. The nominal codes (N0, N1) are (856, 733) for the big range and (833, 80) for the small range.
- R9: Before any load, the points (a0, a1) are (3310, 2832) for the big range and (3413, 341) for the small range.
- R10: If a0 equals a1 for the chosen range, or if n is 0 on a rescaled channel, the result has `out_err` = 1 and `out_mv` = 0. A zero n on channel 1 or 5 is not an error.
- R11: Requests offered while a conversion is in flight are ignored. They produce no extra result and do not change the result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_load | input | 1 | Store `cal_word` for one range this cycle |
| cal_big | input | 1 | Range written by a load: 1 big, 0 small |
| cal_word | input | 16 | Fuse offsets: [7:0] for a0, [15:8] for a1 |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_code | input | 12 | Raw converter code |
| in_chan | input | 5 | Channel number |
| in_big | input | 1 | Range for channels other than 1 and 5 |
| in_ratio | input | 32 | Numerator [31:16], denominator [15:0] |
| out_valid | output | 1 | One-cycle result strobe |
| out_mv | output | 48 | Voltage in millivolts |
| out_err | output | 1 | Degenerate graph or zero numerator |

## Verification
The bench sweeps the full code range on both direct channels and on a rescaled channel. It does this under the uncalibrated points and under several loaded calibrations, and compares every result with arithmetic worked out in the bench. One calibration puts a1 above some codes, so the intermediate product is negative. A design that rounds such a quotient downward instead of toward zero would be one millivolt low, and a design that misses the clamp would report a wrapped huge value near code 0. Further cases cover a calibration that makes the two points equal and a zero numerator on both a rescaled channel and a direct channel. A design that divides anyway, or that flags the direct channel, would give a wrong value or a false error. Requests held on the input during a conversion would, if accepted, show up as a second strobe or a corrupted result.

// File: rtl/adcv_pkg.sv
package adcv_pkg;

    localparam int PT_W = 16;

    typedef logic signed [PT_W-1:0] pt_t;

    typedef struct packed {
        pt_t a0;
        pt_t a1;
    } graph_pts_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV1,
        ST_POST,
        ST_DIV2,
        ST_DONE
    } state_e;

    localparam int BIG_V0 = 4200;
    localparam int BIG_V1 = 3600;
    localparam int SM_V0  = 1000;
    localparam int SM_V1  = 100;

    localparam int BIG_NOM0 = 856;
    localparam int BIG_NOM1 = 733;
    localparam int SM_NOM0  = 833;
    localparam int SM_NOM1  = 80;

    localparam int BIG_DEF0 = 3310;
    localparam int BIG_DEF1 = 2832;
    localparam int SM_DEF0  = 3413;
    localparam int SM_DEF1  = 341;

    localparam int CH_BIG_DIRECT   = 5;
    localparam int CH_SMALL_DIRECT = 1;

    function automatic pt_t fuse_point(input logic [7:0] offs, input int nominal);
        int tmp;
        tmp = (int'(offs) + nominal - 128) * 4;
        return pt_t'(tmp);
    endfunction

endpackage

// File: rtl/adcv_cal_pts.sv
module adcv_cal_pts
    import adcv_pkg::*;
#(
    parameter int NOM0 = 833,
    parameter int NOM1 = 80,
    parameter int DEF0 = 3413,
    parameter int DEF1 = 341
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [15:0] word,
    output graph_pts_t  pts
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pts.a0 <= pt_t'(DEF0);
            pts.a1 <= pt_t'(DEF1);
        end else if (load) begin
            pts.a0 <= fuse_point(word[7:0], NOM0);
            pts.a1 <= fuse_point(word[15:8], NOM1);
        end
    end

endmodule

// File: rtl/adcv_rdiv.sv
module adcv_rdiv #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q, quo_q, dsr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       trial, diff;
    logic             fits;

    always_comb begin
        trial = {rem_q, quo_q[W-1]};
        diff  = trial - {1'b0, dsr_q};
        fits  = (trial >= {1'b0, dsr_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= dividend;
                dsr_q <= divisor;
                cnt_q <= CNT_W'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    // R2: the controller never restarts the divider mid-run
    p_no_restart_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

    // R2: completion is a single-cycle strobe that ends a busy run
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_after_busy_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

endmodule

// File: rtl/adcv_conv_top.sv
module adcv_conv_top
    import adcv_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int CHAN_W = 5,
    parameter int DIV_W  = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_load,
    input  logic              cal_big,
    input  logic [15:0]       cal_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] in_code,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic              in_big,
    input  logic [31:0]       in_ratio,
    output logic              out_valid,
    output logic [DIV_W-1:0]  out_mv,
    output logic              out_err
);

    localparam int NUM_GRAPHS = 2;
    localparam int RN_W = 16;

    // graph index 1 = big range, 0 = small range
    graph_pts_t pts_arr [NUM_GRAPHS];

    for (genvar g = 0; g < NUM_GRAPHS; g++) begin : g_graph
        localparam int N0 = (g == 1) ? BIG_NOM0 : SM_NOM0;
        localparam int N1 = (g == 1) ? BIG_NOM1 : SM_NOM1;
        localparam int D0 = (g == 1) ? BIG_DEF0 : SM_DEF0;
        localparam int D1 = (g == 1) ? BIG_DEF1 : SM_DEF1;
        adcv_cal_pts #(.NOM0(N0), .NOM1(N1), .DEF0(D0), .DEF1(D1)) u_pts (
            .clk  (clk),
            .rst  (rst),
            .load (cal_load && (cal_big == (g == 1))),
            .word (cal_word),
            .pts  (pts_arr[g])
        );
    end

    state_e              state_q;
    logic [CODE_W-1:0]   code_q;
    logic                big_q, direct_q, neg_q, err_q;
    logic [31:0]         ratio_q;
    pt_t                 a0_q, a1_q;
    logic [DIV_W-1:0]    volt_q, res_q;

    logic                accept, use_big, is_direct;
    logic signed [31:0]  a0_s, a1_s, code_s, diff_s, dv_s, v1_s, prod_s, den_s;
    logic signed [31:0]  q_s, t_s;
    logic [31:0]         prod_mag, den_mag, t_clamp;
    logic [RN_W-1:0]     rnum, rden;
    logic [DIV_W-1:0]    ratio_dividend;
    logic                div_start, div_busy, div_done;
    logic [DIV_W-1:0]    div_dividend, div_divisor, div_quo;

    assign accept    = in_valid && in_ready;
    assign is_direct = (in_chan == CHAN_W'(CH_BIG_DIRECT)) ||
                       (in_chan == CHAN_W'(CH_SMALL_DIRECT));
    assign use_big   = (in_chan == CHAN_W'(CH_BIG_DIRECT))   ? 1'b1 :
                       (in_chan == CHAN_W'(CH_SMALL_DIRECT)) ? 1'b0 : in_big;

    // interpolation operands
    always_comb begin
        a0_s     = 32'(a0_q);
        a1_s     = 32'(a1_q);
        code_s   = signed'(32'(code_q));
        diff_s   = code_s - a1_s;
        dv_s     = big_q ? 32'sd600 : 32'sd900;
        v1_s     = big_q ? 32'(BIG_V1) : 32'(SM_V1);
        prod_s   = dv_s * diff_s;
        den_s    = a0_s - a1_s;
        prod_mag = prod_s[31] ? unsigned'(-prod_s) : unsigned'(prod_s);
        den_mag  = den_s[31]  ? unsigned'(-den_s)  : unsigned'(den_s);
        q_s      = signed'(div_quo[31:0]);
        t_s      = (neg_q ? -q_s : q_s) + v1_s;
        t_clamp  = t_s[31] ? 32'd0 : unsigned'(t_s);
    end

    // rescale operands
    always_comb begin
        rnum           = ratio_q[31:16];
        rden           = ratio_q[15:0];
        ratio_dividend = volt_q * DIV_W'(rden) + DIV_W'(rnum >> 1);
    end

    always_comb begin
        div_start    = 1'b0;
        div_dividend = DIV_W'(prod_mag);
        div_divisor  = DIV_W'(den_mag);
        if (state_q == ST_PREP) begin
            div_start = (den_s != 32'sd0);
        end else if (state_q == ST_POST) begin
            div_start    = !direct_q && (rnum != '0);
            div_dividend = ratio_dividend;
            div_divisor  = DIV_W'(rnum);
        end
    end

    adcv_rdiv #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (div_dividend),
        .divisor  (div_divisor),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            code_q   <= '0;
            big_q    <= 1'b0;
            direct_q <= 1'b0;
            neg_q    <= 1'b0;
            err_q    <= 1'b0;
            ratio_q  <= '0;
            a0_q     <= '0;
            a1_q     <= '0;
            volt_q   <= '0;
            res_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        code_q   <= in_code;
                        big_q    <= use_big;
                        direct_q <= is_direct;
                        ratio_q  <= in_ratio;
                        a0_q     <= use_big ? pts_arr[1].a0 : pts_arr[0].a0;
                        a1_q     <= use_big ? pts_arr[1].a1 : pts_arr[0].a1;
                        err_q    <= 1'b0;
                        state_q  <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    if (den_s == 32'sd0) begin
                        err_q   <= 1'b1;
                        res_q   <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        neg_q   <= prod_s[31] ^ den_s[31];
                        state_q <= ST_DIV1;
                    end
                end
                ST_DIV1: begin
                    if (div_done) begin
                        volt_q  <= DIV_W'(t_clamp);
                        state_q <= ST_POST;
                    end
                end
                ST_POST: begin
                    if (direct_q) begin
                        res_q   <= volt_q;
                        state_q <= ST_DONE;
                    end else if (rnum == '0) begin
                        err_q   <= 1'b1;
                        res_q   <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_DIV2;
                    end
                end
                ST_DIV2: begin
                    if (div_done) begin
                        res_q   <= div_quo;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_DONE);
    assign out_mv    = res_q;
    assign out_err   = err_q;

    // R2: handshake and strobe shape
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
    p_strobe_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    p_ready_after_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> in_ready);
    p_no_ready_with_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R10: an error result carries a zero voltage
    p_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (out_mv == '0));

    // R5: direct channels never use the divider for a second pass
    p_direct_single_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POST && direct_q) |-> !div_start);

endmodule

// File: tb/adcv_conv_top_bench.sv
module adcv_conv_top_bench;

    localparam int CW = 12;
    localparam int HW = 5;
    localparam int DW = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cal_load = 1'b0, cal_big = 1'b0;
    logic [15:0]   cal_word = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [CW-1:0] in_code = '0;
    logic [HW-1:0] in_chan = '0;
    logic          in_big = 1'b0;
    logic [31:0]   in_ratio = '0;
    logic          out_valid;
    logic [DW-1:0] out_mv;
    logic          out_err;

    int checks = 0;
    int fails  = 0;
    bit summary_done = 1'b0;

    // bench model of calibration points: index 1 big, 0 small
    int m_a0 [2] = '{3413, 3310};
    int m_a1 [2] = '{341, 2832};

    always #10 clk = ~clk;

    adcv_conv_top u_adcv_conv_top (
        .clk(clk), .rst(rst), .cal_load(cal_load), .cal_big(cal_big),
        .cal_word(cal_word), .in_valid(in_valid), .in_ready(in_ready),
        .in_code(in_code), .in_chan(in_chan), .in_big(in_big),
        .in_ratio(in_ratio), .out_valid(out_valid), .out_mv(out_mv),
        .out_err(out_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic void model(input int code, input int chan, input bit big,
                                  input logic [31:0] ratio,
                                  output longint mv, output bit err);
        int g;
        longint v0, v1, a0, a1, t, n, d;
        g  = (chan == 5) ? 1 : (chan == 1) ? 0 : int'(big);
        v0 = (g == 1) ? 4200 : 1000;
        v1 = (g == 1) ? 3600 : 100;
        a0 = m_a0[g];
        a1 = m_a1[g];
        err = 1'b0;
        mv  = 0;
        if (a0 == a1) begin
            err = 1'b1;
            return;
        end
        t = (v0 - v1) * (longint'(code) - a1) / (a0 - a1) + v1;
        if (t < 0) t = 0;
        if (chan == 5 || chan == 1) begin
            mv = t;
            return;
        end
        n = longint'(ratio[31:16]);
        d = longint'(ratio[15:0]);
        if (n == 0) begin
            err = 1'b1;
            return;
        end
        mv = (t * d + n / 2) / n;
    endfunction

    task automatic load_cal(input bit big, input int b0, input int b1);
        @(negedge clk);
        cal_load = 1'b1;
        cal_big  = big;
        cal_word = {8'(b1), 8'(b0)};
        @(negedge clk);
        cal_load = 1'b0;
        m_a0[int'(big)] = (b0 + (big ? 856 : 833) - 128) * 4;
        m_a1[int'(big)] = (b1 + (big ? 733 : 80) - 128) * 4;
    endtask

    task automatic convert(input int code, input int chan, input bit big,
                           input logic [31:0] ratio, input bit spam, input string tag);
        longint exp_mv;
        bit     exp_err;
        bit     seen;
        string  req;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_code  = CW'(code);
        in_chan  = HW'(chan);
        in_big   = big;
        in_ratio = ratio;
        model(code, chan, big, ratio, exp_mv, exp_err);
        @(negedge clk);
        check(in_ready == 1'b0, "R2 ready low after accept", longint'(in_ready), 0);
        if (spam) begin
            in_code  = CW'(code) ^ 12'hFFF;
            in_chan  = HW'(chan + 2);
            in_big   = ~big;
            in_ratio = 32'h0003_0007;
            for (int k = 0; k < 8; k++) @(negedge clk);
        end
        in_valid = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 400 && !seen; k++) begin
            if (out_valid) seen = 1'b1;
            else @(negedge clk);
        end
        if (chan == 5) req = {"R3 R5 ", tag};
        else if (chan == 1) req = {"R3 R6 ", tag};
        else req = {"R3 R7 ", tag};
        if (exp_err) req = {"R10 ", req};
        if (spam) req = {"R11 ", req};
        check(seen, {req, " strobe"}, longint'(seen), 1);
        check(out_mv == DW'(exp_mv) && out_err == exp_err,
              $sformatf("%s code=%0d chan=%0d err=%0d", req, code, chan, out_err),
              longint'(out_mv), exp_mv);
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R2 single strobe, ready back",
              longint'({out_valid, in_ready}), 1);
    endtask

    function automatic logic [31:0] pick_ratio(input int i);
        case (i % 5)
            0: return {16'd100, 16'd406};
            1: return {16'd1000, 16'd1955};
            2: return {16'd3, 16'd8};
            3: return {16'd68, 16'd900};
            default: return {16'd1, 16'd1};
        endcase
    endfunction

    task automatic sweep(input string tag);
        for (int i = 0; i <= 32; i++) begin
            int code;
            code = (i == 32) ? 4095 : i * 128;
            convert(code, 5, i[0], pick_ratio(i), 1'b0, tag);
            convert(code, 1, i[1], pick_ratio(i + 1), 1'b0, tag);
            convert(code, (i % 3 == 0) ? 0 : 17, i[2], pick_ratio(i), 1'b0, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1 handshake reset",
              longint'({in_ready, out_valid}), 2);
        check(out_mv == '0 && out_err == 1'b0, "R1 result reset", longint'(out_mv), 0);

        // R9: uncalibrated points
        sweep("R9");

        // R8: nominal offsets on small, shifted big
        load_cal(1'b0, 128, 128);
        load_cal(1'b1, 10, 200);
        sweep("R8");

        // R4: small a1 above low codes forces negative interpolation
        load_cal(1'b0, 0, 255);
        load_cal(1'b1, 255, 0);
        sweep("R4 R8");
        convert(0, 1, 1'b0, 32'h0, 1'b0, "R4 clamp");
        convert(640, 1, 1'b0, 32'h0, 1'b0, "R3 truncation");

        // R10: zero numerator on rescaled channel, not on direct one
        convert(2000, 3, 1'b0, {16'd0, 16'd50}, 1'b0, "R10 num zero");
        convert(2000, 1, 1'b0, {16'd0, 16'd50}, 1'b0, "R10 direct ok");
        convert(2000, 5, 1'b0, {16'd0, 16'd50}, 1'b0, "R10 direct ok");

        // R10: equal points on big range
        load_cal(1'b1, 0, 123);
        convert(3000, 5, 1'b0, {16'd1, 16'd1}, 1'b0, "R10 flat graph");
        convert(3000, 9, 1'b1, {16'd1, 16'd1}, 1'b0, "R10 flat graph");
        convert(3000, 9, 1'b0, {16'd7, 16'd29}, 1'b0, "R7 small unaffected");

        // R11: requests held during conversion
        load_cal(1'b1, 40, 90);
        convert(1500, 5, 1'b0, {16'd1, 16'd1}, 1'b1, "R11");
        convert(3100, 1, 1'b1, {16'd2, 16'd3}, 1'b1, "R11");
        convert(2500, 12, 1'b1, {16'd375, 16'd1955}, 1'b1, "R11");

        finish_run();
    end

endmodule